// File: doc/BRIEF.md
# Supply Reset Supervisor with Watchdog

This block generates an active-low system reset for a processor subsystem. A digital supply-good flag gates it. While the flag is low, reset is held asserted. When the flag goes high, reset stays asserted for a programmable number of clock cycles and is then released.

After release, a watchdog counts clock cycles. The processor must change the level of the watchdog input often enough to keep the count from reaching the programmed limit. Rising and falling changes both count. If the limit is reached, the block enters the same timed reset pulse used at power-up, and the watchdog restarts when that pulse ends. A processor that stays silent therefore receives a periodic train of reset pulses.

Both lengths are cycle counts taken from input ports. Each count is captured when the interval it governs begins. The watchdog input is asynchronous and passes through a two-flop synchronizer before edge detection.

Top module: `sup_rst_wdog`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and right after it is released, `sys_rst_n` is low. The block starts in the supply-hold state with both counters at zero.
- R2: In any cycle where `supply_ok` is low, `sys_rst_n` is low in that same cycle, with no register delay. It stays low until the supply is good again.
- R3: `sys_rst_n` rises exactly `rst_cycles` clock edges after the first rising edge at which `supply_ok` is sampled high.
- R4: With no change on `wd_toggle`, `sys_rst_n` falls `wd_cycles` edges after its release. It then stays low for `rst_cycles` cycles and rises again, and this repeats.
- R5: A level change on `wd_toggle`, in either direction, restarts the watchdog from zero while reset stays released. The change takes effect at the third rising edge after it is applied, through two synchronizer flops and one edge-detect flop. The next timeout then falls `wd_cycles` edges after that edge.
- R6: Changes on `wd_toggle` while reset is asserted do not lengthen or shorten the reset pulse. The watchdog count is zero throughout reset and starts from zero at release.
- R7: A period value of 0 behaves as 1: one cycle of reset, or one cycle of watchdog window.
- R8: `rst_cycles` is captured when a reset pulse begins. `wd_cycles` is captured at release and at each watchdog restart. A change in the middle of an interval affects only later intervals.
- R9: Loss of the supply during a reset pulse or during the watchdog window abandons that timing. When the supply returns, a full `rst_cycles` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| supply_ok | input | 1 | Supply-good flag, synchronous to clk, high when the supply is above its trip point |
| wd_toggle | input | 1 | Watchdog input toggled by the processor, asynchronous |
| rst_cycles | input | CW | Reset pulse length in clock cycles |
| wd_cycles | input | CW | Watchdog window length in clock cycles |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
A supply drop shows at `sys_rst_n` in the same cycle. A supply rise releases reset `rst_cycles` edges after the edge that samples it. A watchdog toggle acts on the third edge after it is applied, so a kick placed four samples into the window yields a high run of `wd_cycles + 6` samples. The bench drives inputs on the falling edge and samples 2 ns after each rising edge. A behavioural model is advanced on the same rising edge and compared at every sample. Directed checks measure the lengths of high and low runs at those same sample points against the counts above.

// File: rtl/sup_wd_pkg.sv
package sup_wd_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } sup_state_e;
endpackage

// File: rtl/sup_kick_sync.sv
// Synchronizer chain plus one history flop; flags any level change.
module sup_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  generate
    if (STAGES >= 1) begin : g_edge
      assign edge_o = sh_q[LAST] ^ sh_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/sup_period_timer.sv
// Up-counter that captures its limit on start and flags the last cycle.
module sup_period_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + ONE;
  assign expire_o = (cnt_inc >= {1'b0, len_q});

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (start_i) begin
      cnt_d = '0;
      len_d = len_i;
    end else if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = cnt_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/sup_seq_fsm.sv
// Sequencer: supply hold -> reset stretch -> watchdog run.
module sup_seq_fsm
  import sup_wd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       kick_i,
  input  logic       rt_exp_i,
  input  logic       wd_exp_i,
  output logic       rt_start_o,
  output logic       rt_clr_o,
  output logic       rt_run_o,
  output logic       wd_start_o,
  output logic       wd_clr_o,
  output logic       wd_run_o,
  output sup_state_e state_o
);
  sup_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    rt_start_o = 1'b0;
    rt_run_o   = 1'b0;
    wd_start_o = 1'b0;
    wd_run_o   = 1'b0;
    case (st_q)
      ST_HOLD: begin
        if (supply_ok_i) begin
          st_d       = ST_STRETCH;
          rt_start_o = 1'b1;
        end
      end
      ST_STRETCH: begin
        if (!supply_ok_i) begin
          st_d = ST_HOLD;
        end else if (rt_exp_i) begin
          st_d       = ST_RUN;
          wd_start_o = 1'b1;
        end else begin
          rt_run_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (!supply_ok_i) begin
          st_d = ST_HOLD;
        end else if (kick_i) begin
          wd_start_o = 1'b1;
        end else if (wd_exp_i) begin
          st_d       = ST_STRETCH;
          rt_start_o = 1'b1;
        end else begin
          wd_run_o = 1'b1;
        end
      end
      default: st_d = ST_HOLD;
    endcase
    rt_clr_o = (st_d == ST_HOLD);
    wd_clr_o = (st_d != ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
  import sup_wd_pkg::*;
#(
  parameter int CW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          wd_toggle,
  input  logic [CW-1:0] rst_cycles,
  input  logic [CW-1:0] wd_cycles,
  output logic          sys_rst_n
);
  sup_state_e state_q;
  logic wd_edge;
  logic rt_start, rt_clr, rt_run, rt_exp;
  logic wd_start, wd_clr, wd_run, wd_exp;

  sup_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (wd_toggle),
    .edge_o(wd_edge)
  );

  sup_period_timer #(.CW(CW)) u_rt_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rt_start),
    .clr_i   (rt_clr),
    .run_i   (rt_run),
    .len_i   (rst_cycles),
    .expire_o(rt_exp)
  );

  sup_period_timer #(.CW(CW)) u_wd_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wd_start),
    .clr_i   (wd_clr),
    .run_i   (wd_run),
    .len_i   (wd_cycles),
    .expire_o(wd_exp)
  );

  sup_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_i(supply_ok),
    .kick_i     (wd_edge),
    .rt_exp_i   (rt_exp),
    .wd_exp_i   (wd_exp),
    .rt_start_o (rt_start),
    .rt_clr_o   (rt_clr),
    .rt_run_o   (rt_run),
    .wd_start_o (wd_start),
    .wd_clr_o   (wd_clr),
    .wd_run_o   (wd_run),
    .state_o    (state_q)
  );

  // A bad supply forces reset without waiting for a clock edge (R2).
  assign sys_rst_n = (state_q == ST_RUN) && supply_ok;
endmodule

// File: rtl/sup_rst_wdog_chk.sv
module sup_rst_wdog_chk
  import sup_wd_pkg::*;
#(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          sys_rst_n,
  input sup_state_e    st,
  input logic          kick,
  input logic          rt_exp,
  input logic          wd_exp,
  input logic [CW-1:0] wd_cnt,
  input logic [CW-1:0] rt_cnt
);
  a_r2_bad_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !sys_rst_n);

  a_r2_bad_supply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st == ST_HOLD));

  a_r3_release_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STRETCH && supply_ok && rt_exp) |=> (st == ST_RUN && wd_cnt == '0));

  a_r4_timeout_restretch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && supply_ok && !kick && wd_exp) |=> (st == ST_STRETCH && rt_cnt == '0));

  a_r5_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && supply_ok && kick) |=> (st == ST_RUN && wd_cnt == '0));

  a_r6_wd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |-> (wd_cnt == '0));

  a_r6_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STRETCH && supply_ok && kick && !rt_exp) |=> (st == ST_STRETCH));
endmodule

bind sup_rst_wdog sup_rst_wdog_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_ok(supply_ok),
  .sys_rst_n(sys_rst_n),
  .st       (state_q),
  .kick     (wd_edge),
  .rt_exp   (rt_exp),
  .wd_exp   (wd_exp),
  .wd_cnt   (u_wd_tmr.cnt_q),
  .rt_cnt   (u_rt_tmr.cnt_q)
);

// File: tb/sim_sup_rst_wdog.sv
`timescale 1ns/1ps
module sim_sup_rst_wdog;
  localparam int CW = 20;

  logic          clk = 1'b0;
  logic          rst_n, supply_ok, wd_toggle;
  logic [CW-1:0] rst_cycles, wd_cycles;
  logic          sys_rst_n;

  always #5 clk = ~clk;

  sup_rst_wdog #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_toggle(wd_toggle),
    .rst_cycles(rst_cycles), .wd_cycles(wd_cycles), .sys_rst_n(sys_rst_n)
  );

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";
  logic  last_v;
  bit    done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 = supply hold, 1 = reset pulse, 2 = released.
  int   m_mode, m_cnt, m_lim;
  logic hist [$];
  bit   m_kick;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_lim = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      m_kick = (hist[1] != hist[2]);            // change reaches the sequencer two edges late
      hist.push_front(wd_toggle);
      void'(hist.pop_back());
      if (!supply_ok) m_mode = 0;
      else if (m_mode == 0) begin m_mode = 1; m_cnt = 0; m_lim = (rst_cycles == 0) ? 1 : int'(rst_cycles); end
      else if (m_mode == 1) begin
        if (m_cnt + 1 >= m_lim) begin m_mode = 2; m_cnt = 0; m_lim = (wd_cycles == 0) ? 1 : int'(wd_cycles); end
        else m_cnt++;
      end else begin
        if (m_kick) begin m_cnt = 0; m_lim = (wd_cycles == 0) ? 1 : int'(wd_cycles); end
        else if (m_cnt + 1 >= m_lim) begin m_mode = 1; m_cnt = 0; m_lim = (rst_cycles == 0) ? 1 : int'(rst_cycles); end
        else m_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      logic e;
      e = rst_n && (m_mode == 2) && supply_ok;
      check(sys_rst_n === e, cur_req, int'(sys_rst_n), int'(e));
    end
  end

  task automatic smp();
    @(posedge clk); #2;
  endtask

  task automatic run_len(inout int n);
    forever begin
      smp();
      if (sys_rst_n === last_v) n++;
      else begin last_v = sys_rst_n; break; end
      if (n > 100000) break;
    end
  endtask

  task automatic wait_change(input logic to);
    logic prev;
    forever begin
      prev = sys_rst_n;
      smp();
      if (prev !== to && sys_rst_n === to) break;
    end
    last_v = to;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; supply_ok = 0; wd_toggle = 0; rst_cycles = 5; wd_cycles = 12;
    repeat (3) @(negedge clk);
    check(sys_rst_n === 1'b0, "R1", int'(sys_rst_n), 0);
    rst_n = 1;
    cur_req = "R2";
    repeat (3) smp();
    check(sys_rst_n === 1'b0, "R2", int'(sys_rst_n), 0);

    // R3 power-up stretch, then R4 periodic pulses
    cur_req = "R3";
    @(negedge clk) supply_ok = 1;
    smp(); last_v = sys_rst_n;
    check(sys_rst_n === 1'b0, "R3", int'(sys_rst_n), 0);
    n = 1; run_len(n); check(n == 5, "R3", n, 5);
    cur_req = "R4";
    n = 1; run_len(n); check(n == 12, "R4", n, 12);
    n = 1; run_len(n); check(n == 5, "R4", n, 5);
    n = 1; run_len(n); check(n == 12, "R4", n, 12);

    // R5 rising then falling kick, four samples into the window
    cur_req = "R5";
    for (int k = 0; k < 2; k++) begin
      wait_change(1);
      n = 1;
      repeat (3) begin smp(); n++; end
      @(negedge clk) wd_toggle = ~wd_toggle;
      run_len(n); check(n == 12 + 6, "R5", n, 18);
    end
    wait_change(1);
    for (int k = 0; k < 10; k++) begin
      repeat (5) smp();
      check(sys_rst_n === 1'b1, "R5", int'(sys_rst_n), 1);
      @(negedge clk) wd_toggle = ~wd_toggle;
    end

    // R6 toggles during a pulse are ignored
    cur_req = "R6";
    @(negedge clk) rst_cycles = 8;
    wait_change(1);
    wait_change(0);
    n = 1;
    @(negedge clk) wd_toggle = ~wd_toggle;
    run_len(n); check(n == 8, "R6", n, 8);
    n = 1; run_len(n); check(n == 12, "R6", n, 12);

    // R8 mid-interval changes wait for the next interval
    cur_req = "R8";
    n = 1;
    @(negedge clk) rst_cycles = 3;
    run_len(n); check(n == 8, "R8", n, 8);
    n = 1;
    @(negedge clk) wd_cycles = 20;
    run_len(n); check(n == 12, "R8", n, 12);
    n = 1; run_len(n); check(n == 3, "R8", n, 3);
    n = 1; run_len(n); check(n == 20, "R8", n, 20);

    // R7 zero periods act as one
    cur_req = "R7";
    @(negedge clk) begin rst_cycles = 0; wd_cycles = 0; end
    wait_change(1);
    wait_change(0);
    n = 1; run_len(n); check(n == 1, "R7", n, 1);
    n = 1; run_len(n); check(n == 1, "R7", n, 1);

    // R2 / R9 supply loss
    cur_req = "R9";
    @(negedge clk) begin rst_cycles = 5; wd_cycles = 12; end
    wait_change(0);
    wait_change(1);
    smp(); smp();
    @(negedge clk) supply_ok = 0;
    #1 check(sys_rst_n === 1'b0, "R2", int'(sys_rst_n), 0);
    repeat (4) smp();
    check(sys_rst_n === 1'b0, "R2", int'(sys_rst_n), 0);
    @(negedge clk) supply_ok = 1;
    smp(); last_v = sys_rst_n;
    n = 1; run_len(n); check(n == 5, "R9", n, 5);
    wait_change(0);
    smp(); smp();
    @(negedge clk) supply_ok = 0;
    smp();
    @(negedge clk) supply_ok = 1;
    smp(); last_v = sys_rst_n;
    n = 1; run_len(n); check(n == 5, "R9", n, 5);

    repeat (5) smp();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule